// File: doc/BRIEF.md
# SPI flash manual-mode sequencer

This block is a single-lane SPI master that runs one framed flash transaction each time it accepts a start request. A frame is built from up to four phases that always run in a fixed order: an 8-bit command, a 24-bit address, a programmable run of dummy clocks and a 32-bit data word that is either sent or captured. Each phase has its own enable. A phase that is not enabled is skipped, and the phases that follow it move up to take its place.

The surrounding register logic drives the phase enables, the opcode, the address, the dummy length, the write word, three chip-select timing delays and the control bits. It then raises start for one cycle. The block copies the whole configuration at the moment it accepts the start, so the inputs may change while a frame runs. Completion is reported by an end flag, a busy output and a select-active flag. A keep-select control leaves chip-select low after a frame ends, so that several frames (for example a command and address frame followed by one or more 32-bit data frames) form a single flash transaction. The bus runs in SPI mode 0 with one bit per SCK period. Each SCK half lasts one clock cycle.

Top module: `sfl_seq`

## Requirements
- R1: Enabled phases always run in the order command, address, dummy, data. A disabled phase is skipped with no gap, and every field is sent most significant bit first.
- R2: When cmd_en_i is 1 the frame starts with the 8 bits of cmd_i. When cmd_en_i is 0 no command bits are sent.
- R3: addr_code_i = 4'h7 sends the 24 bits of addr_i. Any other code gives no address phase.
- R4: When dmy_en_i is 1 the dummy phase lasts dmy_cnt_i + 1 SCK clocks with mosi_o held low. When dmy_en_i is 0 there is no dummy phase.
- R5: data_code_i = 4'hF together with wr_i or rd_i gives a 32-bit data phase. With wr_i the block sends wdata_i; wr_i takes precedence on mosi_o, and with rd_i alone mosi_o is low. With rd_i the block captures miso_i during each SCK high half into rdata_o, most significant bit first. Any other data code gives no data phase, and rdata_o keeps its value.
- R6: The bus uses SPI mode 0. sck_o is low when idle. Every SCK high half lasts exactly one clock cycle and occurs only while cs_no is low. mosi_o changes only while sck_o is low and is low outside bit slots.
- R7: Chip-select timing is programmable. The first SCK high half comes sck_dly_i + 1 cycles after cs_no falls. cs_no stays low for end_dly_i + 1 cycles after the last SCK high half. After cs_no rises it stays high for idle_dly_i + 1 cycles before the frame ends.
- R8: A start accepted while idle clears xfer_end_o and raises busy_o in the next cycle. xfer_end_o rises in the cycle busy_o falls. A frame with no phases enabled still selects the device and applies the delays.
- R9: With keep_sel_i set, cs_no stays low after the frame and sel_act_o stays high. The next start skips the select-to-clock delay and begins with a one-cycle low half. If that next start enables no phases, it goes straight to the deselect delay.
- R10: A start that arrives while busy_o is high is ignored, and so are configuration changes made during the frame.
- R11: After reset, cs_no is high, sck_o and mosi_o are low, busy_o and xfer_end_o are low, and rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| wr_i | input | 1 | Data phase sends wdata_i |
| rd_i | input | 1 | Data phase captures miso_i |
| keep_sel_i | input | 1 | Keep chip-select low after the frame |
| cmd_en_i | input | 1 | Command phase enable |
| cmd_i | input | 8 | Opcode |
| addr_code_i | input | 4 | Address phase code (7 = 24 bits) |
| addr_i | input | 24 | Address |
| dmy_en_i | input | 1 | Dummy phase enable |
| dmy_cnt_i | input | 4 | Dummy clocks minus one |
| data_code_i | input | 4 | Data phase code (F = 32 bits) |
| wdata_i | input | 32 | Write word |
| sck_dly_i | input | 3 | Select-to-clock delay minus one |
| end_dly_i | input | 3 | Clock-to-deselect delay minus one |
| idle_dly_i | input | 3 | Minimum deselect time minus one |
| miso_i | input | 1 | Serial data from the device |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip-select, active low |
| mosi_o | output | 1 | Serial data to the device |
| rdata_o | output | 32 | Captured read word |
| xfer_end_o | output | 1 | Frame complete |
| sel_act_o | output | 1 | Chip-select currently asserted |
| busy_o | output | 1 | Frame in progress |

## Verification
The assertions check on every cycle the rules that hold in any frame. SCK may be high only while the device is selected, and only for one cycle at a time. mosi_o must not change across a high half. The end flag and busy must never be high together. Chip-select may only be released while a frame is still running. A start that arrives while busy must leave the latched configuration unchanged. The phase order, the bit values, the lengths of the dummy phase and the delays, the behaviour of chained keep-select frames and the captured read word all depend on the programmed configuration. These can only be shown by the bench scenarios, where a behavioural model lists the expected pin values for every cycle of the frame.

// File: rtl/sfl_seq_pkg.sv
package sfl_seq_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int DMY_W  = 4;
  localparam int DLY_W  = 3;
  localparam int CNT_W  = $clog2(DATA_W) + 1;

  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,
    PH_ADDR = 3'd1,
    PH_DMY  = 3'd2,
    PH_DATA = 3'd3,
    PH_NONE = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD, S_GAP
  } state_e;

  typedef struct packed {
    logic              cmd_en;
    logic              addr_en;
    logic              dmy_en;
    logic              data_en;
    logic              wr;
    logic              rd;
    logic              keep;
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DMY_W-1:0]  dmy;
    logic [DATA_W-1:0] wdata;
    logic [DLY_W-1:0]  end_dly;
    logic [DLY_W-1:0]  idle_dly;
  } cfg_t;

  // first enabled phase strictly after cur; PH_NONE as cur means from the start
  function automatic phase_e phase_after(phase_e cur, cfg_t c);
    logic [3:0] en;
    phase_e     p;
    int         lo;
    en = {c.data_en & (c.wr | c.rd), c.dmy_en, c.addr_en, c.cmd_en};
    lo = (cur == PH_NONE) ? 0 : int'(cur) + 1;
    p  = PH_NONE;
    for (int i = 3; i >= 0; i--) begin
      if (i >= lo && en[i]) p = phase_e'(3'(i));
    end
    return p;
  endfunction

  function automatic logic [CNT_W-1:0] phase_last(phase_e p, cfg_t c);
    case (p)
      PH_CMD:  return CNT_W'(CMD_W - 1);
      PH_ADDR: return CNT_W'(ADDR_W - 1);
      PH_DMY:  return CNT_W'(c.dmy);
      PH_DATA: return CNT_W'(DATA_W - 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] phase_word(phase_e p, cfg_t c);
    case (p)
      PH_CMD:  return {c.cmd, {(DATA_W-CMD_W){1'b0}}};
      PH_ADDR: return {c.addr, {(DATA_W-ADDR_W){1'b0}}};
      PH_DATA: return c.wr ? c.wdata : '0;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sfl_seq_cfg.sv
module sfl_seq_cfg
  import sfl_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sfl_seq_dly.sv
module sfl_seq_dly #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sfl_seq_shift.sv
module sfl_seq_shift #(
  parameter int DW = 32,
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          shift_i,
  input  logic          cap_i,
  input  logic          miso_i,
  output logic          msb_o,
  output logic [CW-1:0] idx_o,
  output logic [DW-1:0] rx_o
);
  logic [DW-1:0] tx_q, rx_q;
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      tx_q  <= word_i;
      idx_q <= '0;
    end else if (shift_i) begin
      tx_q  <= {tx_q[DW-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rx_q <= '0;
    else if (cap_i) rx_q <= {rx_q[DW-2:0], miso_i};
  end

  assign msb_o = tx_q[DW-1];
  assign idx_o = idx_q;
  assign rx_o  = rx_q;

  // R5: capture and shift-out of a bit never coincide with a reload
  a_r5_cap_not_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !(load_i && shift_i));
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              keep_sel_i,
  input  logic              cmd_en_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [3:0]        addr_code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dmy_en_i,
  input  logic [DMY_W-1:0]  dmy_cnt_i,
  input  logic [3:0]        data_code_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DLY_W-1:0]  sck_dly_i,
  input  logic [DLY_W-1:0]  end_dly_i,
  input  logic [DLY_W-1:0]  idle_dly_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              xfer_end_o,
  output logic              sel_act_o,
  output logic              busy_o
);
  localparam logic [3:0] ADDR_FULL = 4'h7;
  localparam logic [3:0] DATA_FULL = 4'hF;

  cfg_t   cfg_d, cfg_q;
  state_e st_q;
  phase_e ph_q, first_ph, nxt_ph;

  logic             accept, last_bit;
  logic             dly_ld, dly_zero;
  logic [DLY_W-1:0] dly_val;
  logic             sh_ld, sh_shift, sh_cap, tx_msb;
  logic [DATA_W-1:0] sh_word;
  logic [CNT_W-1:0] bit_idx;
  logic             cs_n_q, end_q, held_q;

  always_comb begin
    cfg_d          = '0;
    cfg_d.cmd_en   = cmd_en_i;
    cfg_d.addr_en  = (addr_code_i == ADDR_FULL);
    cfg_d.dmy_en   = dmy_en_i;
    cfg_d.data_en  = (data_code_i == DATA_FULL);
    cfg_d.wr       = wr_i;
    cfg_d.rd       = rd_i;
    cfg_d.keep     = keep_sel_i;
    cfg_d.cmd      = cmd_i;
    cfg_d.addr     = addr_i;
    cfg_d.dmy      = dmy_cnt_i;
    cfg_d.wdata    = wdata_i;
    cfg_d.end_dly  = end_dly_i;
    cfg_d.idle_dly = idle_dly_i;
  end

  assign accept   = start_i && (st_q == S_IDLE);
  assign first_ph = phase_after(PH_NONE, cfg_d);
  assign nxt_ph   = phase_after(ph_q, cfg_q);
  assign last_bit = (bit_idx == phase_last(ph_q, cfg_q));

  sfl_seq_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .cfg_i  (cfg_d),
    .cfg_o  (cfg_q)
  );

  // delay counter reloads: setup, deselect, minimum idle
  always_comb begin
    dly_ld  = 1'b0;
    dly_val = '0;
    if (accept) begin
      dly_ld  = 1'b1;
      dly_val = held_q ? end_dly_i : sck_dly_i;
    end else if (st_q == S_SETUP && dly_zero && ph_q == PH_NONE) begin
      dly_ld  = 1'b1;
      dly_val = cfg_q.end_dly;
    end else if (st_q == S_HIGH && last_bit && nxt_ph == PH_NONE) begin
      dly_ld  = 1'b1;
      dly_val = cfg_q.end_dly;
    end else if (st_q == S_HOLD && dly_zero && !cfg_q.keep) begin
      dly_ld  = 1'b1;
      dly_val = cfg_q.idle_dly;
    end
  end

  sfl_seq_dly #(.W(DLY_W)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dly_ld),
    .val_i  (dly_val),
    .zero_o (dly_zero)
  );

  always_comb begin
    sh_ld    = accept || (st_q == S_HIGH && last_bit && nxt_ph != PH_NONE);
    sh_word  = accept ? phase_word(first_ph, cfg_d) : phase_word(nxt_ph, cfg_q);
    sh_shift = (st_q == S_HIGH) && !last_bit;
    sh_cap   = (st_q == S_HIGH) && (ph_q == PH_DATA) && cfg_q.rd;
  end

  sfl_seq_shift #(.DW(DATA_W), .CW(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_ld),
    .word_i  (sh_word),
    .shift_i (sh_shift),
    .cap_i   (sh_cap),
    .miso_i  (miso_i),
    .msb_o   (tx_msb),
    .idx_o   (bit_idx),
    .rx_o    (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ph_q   <= PH_NONE;
      cs_n_q <= 1'b1;
      end_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          end_q <= 1'b0;
          ph_q  <= first_ph;
          if (held_q) begin
            st_q <= (first_ph == PH_NONE) ? S_HOLD : S_LOW;
          end else begin
            cs_n_q <= 1'b0;
            st_q   <= S_SETUP;
          end
        end
        S_SETUP: if (dly_zero) st_q <= (ph_q == PH_NONE) ? S_HOLD : S_HIGH;
        S_LOW:   st_q <= S_HIGH;
        S_HIGH: begin
          if (last_bit) begin
            ph_q <= nxt_ph;
            st_q <= (nxt_ph == PH_NONE) ? S_HOLD : S_LOW;
          end else begin
            st_q <= S_LOW;
          end
        end
        S_HOLD: if (dly_zero) begin
          if (cfg_q.keep) begin
            st_q   <= S_IDLE;
            end_q  <= 1'b1;
            held_q <= 1'b1;
          end else begin
            cs_n_q <= 1'b1;
            held_q <= 1'b0;
            st_q   <= S_GAP;
          end
        end
        S_GAP: if (dly_zero) begin
          st_q  <= S_IDLE;
          end_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sck_o      = (st_q == S_HIGH);
  assign mosi_o     = (st_q == S_SETUP || st_q == S_LOW || st_q == S_HIGH) ? tx_msb : 1'b0;
  assign cs_no      = cs_n_q;
  assign sel_act_o  = !cs_n_q;
  assign busy_o     = (st_q != S_IDLE);
  assign xfer_end_o = end_q;

  a_r6_sck_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  a_r6_sck_high_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);
  a_r6_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));
  a_r8_end_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |-> !busy_o);
  a_r7_release_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> busy_o);
  a_r10_busy_start_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(cfg_q));
  a_r9_held_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && held_q) |-> sel_act_o);
endmodule

// File: tb/sim_sfl_seq.sv
module sim_sfl_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, wr, rd, keep, cmd_en, dmy_en, miso;
  logic [7:0]  cmd;
  logic [3:0]  addr_code, dmy_cnt, data_code;
  logic [23:0] addr;
  logic [31:0] wdata;
  logic [2:0]  sck_dly, end_dly, idle_dly;
  logic        sck, cs_n, mosi, xend, sel, busy;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [2:0]   exp_q[$];
  logic         exp_done = 1'b0, exp_cs_idle = 1'b1, pend_cs = 1'b1, held = 1'b0;
  logic         armed = 1'b0;
  string        cur_tag = "R11";
  logic [127:0] stream = 128'h3C5A_F00F_9966_1E2D_A55A_C3C3_7E81_B4D2;
  int           ridx = 0;
  logic [31:0]  exp_rdata = '0;

  assign miso = stream[ridx];
  always @(negedge sck) ridx = ridx + 1;

  sfl_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .rd_i(rd),
    .keep_sel_i(keep), .cmd_en_i(cmd_en), .cmd_i(cmd), .addr_code_i(addr_code),
    .addr_i(addr), .dmy_en_i(dmy_en), .dmy_cnt_i(dmy_cnt), .data_code_i(data_code),
    .wdata_i(wdata), .sck_dly_i(sck_dly), .end_dly_i(end_dly), .idle_dly_i(idle_dly),
    .miso_i(miso), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .rdata_o(rdata),
    .xfer_end_o(xend), .sel_act_o(sel), .busy_o(busy)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle reference: {busy,end,sel,cs_n,sck,mosi}
  always @(negedge clk) begin
    logic [2:0] e;
    if (armed) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(cur_tag, "frame pins", {busy, xend, sel, cs_n, sck, mosi}, {1'b1, 1'b0, ~e[2], e});
        if (exp_q.size() == 0) begin
          exp_done    = 1'b1;
          exp_cs_idle = pend_cs;
        end
      end else begin
        chk(cur_tag, "idle pins", {busy, xend, sel, cs_n, sck, mosi},
            {1'b0, exp_done, ~exp_cs_idle, exp_cs_idle, 2'b00});
      end
    end
  end

  task automatic clear_cfg();
    wr = 0; rd = 0; keep = 0; cmd_en = 0; cmd = 0; addr_code = 0; addr = 0;
    dmy_en = 0; dmy_cnt = 0; data_code = 0; wdata = 0;
    sck_dly = 0; end_dly = 0; idle_dly = 0;
  endtask

  task automatic fire(string tag);
    logic bits[$];
    int   nb;
    @(negedge clk);
    start = 1'b1;
    #1;
    cur_tag = tag;
    ridx = 0;
    if (cmd_en) for (int i = 7; i >= 0; i--) bits.push_back(cmd[i]);
    if (addr_code == 4'h7) for (int i = 23; i >= 0; i--) bits.push_back(addr[i]);
    if (dmy_en) for (int i = 0; i <= int'(dmy_cnt); i++) bits.push_back(1'b0);
    nb = bits.size();
    if (data_code == 4'hF && (wr || rd)) begin
      for (int i = 31; i >= 0; i--) bits.push_back(wr ? wdata[i] : 1'b0);
      if (rd) for (int k = 0; k < 32; k++) exp_rdata[31-k] = stream[nb+k];
    end
    if (!held)
      for (int i = 0; i <= int'(sck_dly); i++)
        exp_q.push_back({2'b00, (bits.size() > 0) ? bits[0] : 1'b0});
    for (int i = 0; i < bits.size(); i++) begin
      if (i > 0 || held) exp_q.push_back({2'b00, bits[i]});
      exp_q.push_back({2'b01, bits[i]});
    end
    for (int i = 0; i <= int'(end_dly); i++) exp_q.push_back(3'b000);
    if (!keep) for (int i = 0; i <= int'(idle_dly); i++) exp_q.push_back(3'b100);
    pend_cs = !keep;
    held    = keep;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_frame(string tag);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    chk(tag, "rdata", rdata, exp_rdata);
    chk(tag, "end flag", {31'd0, xend}, 32'd1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual=hung expected=frame end");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    clear_cfg();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset pins", {busy, xend, sel, cs_n, sck, mosi}, 6'b000100);
    chk("R11", "reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1'b1;

    // R2 command only
    cmd_en = 1; cmd = 8'hA6;
    fire("R2"); finish_frame("R2");

    // R3 non-7 address code gives no address
    clear_cfg(); cmd_en = 1; cmd = 8'h05; addr_code = 4'h3; addr = 24'hFFFFFF;
    fire("R3"); finish_frame("R3");
    // R3 full address
    addr_code = 4'h7; addr = 24'h12_3456;
    fire("R3"); finish_frame("R3");

    // R1 all phases in order, write data
    clear_cfg(); cmd_en = 1; cmd = 8'h3B; addr_code = 4'h7; addr = 24'hC0_FFEE;
    dmy_en = 1; dmy_cnt = 4'd2; data_code = 4'hF; wr = 1; wdata = 32'hF0E1_D2C3;
    fire("R1"); finish_frame("R1");

    // R4 dummy only then read, long dummy
    clear_cfg(); dmy_en = 1; dmy_cnt = 4'd9; data_code = 4'hF; rd = 1;
    fire("R4"); finish_frame("R4");

    // R5 read after command and address
    clear_cfg(); cmd_en = 1; cmd = 8'h0B; addr_code = 4'h7; addr = 24'h00_0100;
    data_code = 4'hF; rd = 1;
    fire("R5"); finish_frame("R5");
    // R5 non-F data code: no data phase, rdata kept
    data_code = 4'h7;
    fire("R5"); finish_frame("R5");
    // R5 write with read: write word on mosi
    clear_cfg(); data_code = 4'hF; wr = 1; rd = 1; wdata = 32'h8000_0001;
    fire("R5"); finish_frame("R5");

    // R6 alternating pattern write
    clear_cfg(); data_code = 4'hF; wr = 1; wdata = 32'h5555_AAAA;
    fire("R6"); finish_frame("R6");

    // R7 programmed delays
    clear_cfg(); cmd_en = 1; cmd = 8'h9F; sck_dly = 3'd5; end_dly = 3'd3; idle_dly = 3'd6;
    fire("R7"); finish_frame("R7");

    // R8 empty frame
    clear_cfg(); sck_dly = 3'd2; end_dly = 3'd1; idle_dly = 3'd4;
    fire("R8"); finish_frame("R8");

    // R9 chained frames under one select
    clear_cfg(); cmd_en = 1; cmd = 8'h02; addr_code = 4'h7; addr = 24'hAB_CDEF; keep = 1;
    sck_dly = 3'd3;
    fire("R9"); finish_frame("R9");
    repeat (3) @(negedge clk);
    clear_cfg(); data_code = 4'hF; wr = 1; wdata = 32'h1357_9BDF; keep = 1; sck_dly = 3'd4;
    fire("R9"); finish_frame("R9");
    clear_cfg(); data_code = 4'hF; rd = 1; end_dly = 3'd2; idle_dly = 3'd1;
    fire("R9"); finish_frame("R9");
    // R9 held start with no phases
    clear_cfg(); cmd_en = 1; cmd = 8'hC7; keep = 1;
    fire("R9"); finish_frame("R9");
    clear_cfg(); end_dly = 3'd3; idle_dly = 3'd2;
    fire("R9"); finish_frame("R9");

    // R10 start and config changes during a frame are ignored
    clear_cfg(); cmd_en = 1; cmd = 8'h6B; addr_code = 4'h7; addr = 24'h55_00AA;
    fire("R10");
    repeat (10) @(negedge clk);
    cmd = 8'hFF; addr = 24'h0; wr = 1; data_code = 4'hF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_frame("R10");

    repeat (4) @(negedge clk);
    armed = 1'b0;
    summary();
    $finish;
  end
endmodule